// File: doc/BRIEF.md
# Sixth-order sigma-delta IIR lowpass filter

This block turns a one-bit sigma-delta stream into filtered fixed-point samples. When a strobe marks a new modulator bit, the bit becomes a signed fixed-point value of plus or minus one. That value goes to the first of three chained second-order recursive sections. Each section runs five multiply-add operations in a fixed order. It announces its new output with a one-cycle ready pulse, and that pulse starts the next section in the same cycle. The third section's output and ready pulse are the block's registered outputs. Each section takes five coefficients from a packed parameter, so a designed lowpass response (for example a Chebyshev type 1 cascade) can be loaded without touching the RTL.

By default every section has its own multiply-add unit. With `SHARED` set, all three sections take turns on a single unit. A fixed-priority arbiter grants it one operation per cycle. Sharing trades throughput and latency for arithmetic resources: it suits modulator rates that leave at least fifteen clock cycles between bits.

Top module: `sdm_iir6_filter`

## Requirements
- R1: When the input strobe is high, the bit is mapped to the first section's input: a 1 becomes +1.0 (the value 1 shifted left by FRAC, 0x1000_0000 at defaults) and a 0 becomes −1.0 (its two's complement).
- R2: For each input, a section with state x1, x2 computes y = T(b0·u) + x1, then x1 ← T(b1·u) + x2, x2 ← T(b2·u), then x1 ← x1 + T(−a1·y) and x2 ← x2 + T(−a2·y). T(p) is the full product shifted arithmetically right by FRAC, keeping the low W bits, and every sum wraps modulo 2^W. Coefficient k of stage s sits at COEFS[(s·5+k)·W +: W], with k = 0..4 meaning b0, b1, b2, a1, a2.
- R3: In dedicated mode (SHARED = 0), `y_valid` rises exactly 9 cycles after the cycle in which `bit_valid` is high.
- R4: `y_valid` is high for exactly one cycle per input strobe, and `y_data` holds its value until the next pulse.
- R5: In shared mode (SHARED = 1), with at least 15 cycles between strobes, `y_valid` rises exactly 13 cycles after the strobe.
- R6: In shared mode at most one section issues an operation per cycle. Stage 1 always wins, stage 2 wins over stage 3, and the outputs are bit-identical to the dedicated mode.
- R7: In dedicated mode the filter accepts a new strobe every 5 cycles with no loss of exactness.
- R8: A synchronous active-high reset clears the outputs to zero and all section state. The first input after reset then filters from a zero state.
- R9: A section's ready pulse starts the next section in the same cycle, with the finished output as that section's input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: a new modulator bit is present |
| bit_in | input | 1 | Modulator bit, sampled with the strobe |
| y_valid | output | 1 | One-cycle pulse marking a new filtered sample |
| y_data | output | W | Filtered sample, signed, FRAC fractional bits |

## Verification
In dedicated mode, a section can receive a new request in the same cycle that it issues the last feedback operation of the previous sample. The bench provokes this with strobes exactly five cycles apart. In shared mode, a later section can want the multiply-add unit while an earlier one holds it, and this happens on every sample. Both collisions are judged by comparing the output of each mode, every cycle, against a behavioural cascade computed in the bench, including the exact cycle of each valid pulse.

// File: rtl/sdm_iir_pkg.sv
package sdm_iir_pkg;
  // Order in which a section issues its multiply-add operations.
  typedef enum logic [2:0] {
    OP_Y      = 3'd0,
    OP_X1_PRE = 3'd1,
    OP_X2_PRE = 3'd2,
    OP_X1_FB  = 3'd3,
    OP_X2_FB  = 3'd4
  } op_e;

  localparam int NUM_COEF = 5;
endpackage

// File: rtl/sdm_iir_mac.sv
module sdm_iir_mac #(
  parameter int W    = 32,
  parameter int FRAC = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] sig,
  input  logic signed [W-1:0] coef,
  input  logic signed [W-1:0] acc,
  output logic signed [W-1:0] res
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;

  always_comb prod = PW'(sig) * PW'(coef);

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else if (en) res <= W'(prod >>> FRAC) + acc;
  end
endmodule

// File: rtl/sdm_iir_arbiter.sv
module sdm_iir_arbiter #(
  parameter int N      = 3,
  parameter bit SHARED = 1'b0
) (
  input  logic [N-1:0] want,
  output logic [N-1:0] grant
);
  generate
    if (SHARED) begin : g_prio
      assign grant[0] = want[0];
      for (genvar k = 1; k < N; k++) begin : g_lvl
        assign grant[k] = want[k] & ~(|want[k-1:0]);
      end
    end else begin : g_free
      assign grant = want;
    end
  endgenerate
endmodule

// File: rtl/sdm_iir_section.sv
module sdm_iir_section
  import sdm_iir_pkg::*;
#(
  parameter int                W    = 32,
  parameter int                FRAC = 28,
  parameter logic signed [W-1:0] B0 = '0,
  parameter logic signed [W-1:0] B1 = '0,
  parameter logic signed [W-1:0] B2 = '0,
  parameter logic signed [W-1:0] A1 = '0,
  parameter logic signed [W-1:0] A2 = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic signed [W-1:0] req_u,
  input  logic                grant,
  input  logic signed [W-1:0] mac_res,
  output logic                want,
  output logic signed [W-1:0] op_sig,
  output logic signed [W-1:0] op_coef,
  output logic signed [W-1:0] op_acc,
  output logic                rdy,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] NEG_A1 = -A1;
  localparam logic signed [W-1:0] NEG_A2 = -A2;

  logic                active;
  logic [2:0]          step;
  logic                pend_vld;
  logic [2:0]          pend_op;
  logic signed [W-1:0] u_r, x1, x2;

  assign want = active;

  // Operand selection for the operation about to be issued.
  always_comb begin
    op_sig  = u_r;
    op_coef = B0;
    op_acc  = x1;
    case (step)
      OP_X1_PRE: begin op_coef = B1;     op_acc = x2; end
      OP_X2_PRE: begin op_coef = B2;     op_acc = '0; end
      OP_X1_FB:  begin op_sig = y; op_coef = NEG_A1; op_acc = x1; end
      OP_X2_FB:  begin op_sig = y; op_coef = NEG_A2; op_acc = x2; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      step     <= OP_Y;
      pend_vld <= 1'b0;
      pend_op  <= OP_Y;
      u_r      <= '0;
      x1       <= '0;
      x2       <= '0;
      y        <= '0;
      rdy      <= 1'b0;
    end else begin
      pend_vld <= active & grant;
      pend_op  <= step;
      if (active && grant) begin
        if (step == OP_X2_FB) active <= 1'b0;
        step <= step + 3'd1;
      end
      // A new request overrides the end of the previous sequence.
      if (req) begin
        active <= 1'b1;
        step   <= OP_Y;
        u_r    <= req_u;
      end
      rdy <= 1'b0;
      if (pend_vld) begin
        case (pend_op)
          OP_Y:                begin y <= mac_res; rdy <= 1'b1; end
          OP_X1_PRE, OP_X1_FB: x1 <= mac_res;
          OP_X2_PRE, OP_X2_FB: x2 <= mac_res;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdm_iir6_filter.sv
module sdm_iir6_filter
  import sdm_iir_pkg::*;
#(
  parameter int W      = 32,
  parameter int FRAC   = 28,
  parameter bit SHARED = 1'b0,
  parameter logic [3*NUM_COEF*W-1:0] COEFS = {3{
    32'sd265183082, -32'sd531072776, 32'sd293847, 32'sd589426, 32'sd295582
  }}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_valid,
  input  logic                bit_in,
  output logic                y_valid,
  output logic signed [W-1:0] y_data
);
  localparam int NSEC = 3;
  localparam logic signed [W-1:0] FX_ONE = W'(1) << FRAC;

  logic [NSEC-1:0]     req, want, grant, rdy;
  logic signed [W-1:0] req_u   [NSEC];
  logic signed [W-1:0] sec_y   [NSEC];
  logic signed [W-1:0] op_sig  [NSEC];
  logic signed [W-1:0] op_coef [NSEC];
  logic signed [W-1:0] op_acc  [NSEC];
  logic signed [W-1:0] mac_res [NSEC];

  assign req[0]   = bit_valid;
  assign req_u[0] = bit_in ? FX_ONE : -FX_ONE;

  sdm_iir_arbiter #(.N(NSEC), .SHARED(SHARED)) u_arb (
    .want (want),
    .grant(grant)
  );

  generate
    for (genvar s = 0; s < NSEC; s++) begin : g_sec
      if (s > 0) begin : g_link
        assign req[s]   = rdy[s-1];
        assign req_u[s] = sec_y[s-1];
      end
      sdm_iir_section #(
        .W(W), .FRAC(FRAC),
        .B0(COEFS[(s*NUM_COEF+0)*W +: W]),
        .B1(COEFS[(s*NUM_COEF+1)*W +: W]),
        .B2(COEFS[(s*NUM_COEF+2)*W +: W]),
        .A1(COEFS[(s*NUM_COEF+3)*W +: W]),
        .A2(COEFS[(s*NUM_COEF+4)*W +: W])
      ) u_sec (
        .clk(clk), .rst(rst),
        .req(req[s]), .req_u(req_u[s]),
        .grant(grant[s]), .mac_res(mac_res[s]),
        .want(want[s]),
        .op_sig(op_sig[s]), .op_coef(op_coef[s]), .op_acc(op_acc[s]),
        .rdy(rdy[s]), .y(sec_y[s])
      );
    end

    if (SHARED) begin : g_one_mac
      logic signed [W-1:0] sh_sig, sh_coef, sh_acc, sh_res;
      always_comb begin
        sh_sig  = '0;
        sh_coef = '0;
        sh_acc  = '0;
        for (int k = 0; k < NSEC; k++) begin
          if (grant[k]) begin
            sh_sig  |= op_sig[k];
            sh_coef |= op_coef[k];
            sh_acc  |= op_acc[k];
          end
        end
      end
      sdm_iir_mac #(.W(W), .FRAC(FRAC)) u_mac (
        .clk(clk), .rst(rst), .en(|grant),
        .sig(sh_sig), .coef(sh_coef), .acc(sh_acc), .res(sh_res)
      );
      for (genvar s = 0; s < NSEC; s++) begin : g_fan
        assign mac_res[s] = sh_res;
      end
    end else begin : g_own_mac
      for (genvar s = 0; s < NSEC; s++) begin : g_mac
        sdm_iir_mac #(.W(W), .FRAC(FRAC)) u_mac (
          .clk(clk), .rst(rst), .en(grant[s]),
          .sig(op_sig[s]), .coef(op_coef[s]), .acc(op_acc[s]),
          .res(mac_res[s])
        );
      end
    end
  endgenerate

  assign y_valid = rdy[NSEC-1];
  assign y_data  = sec_y[NSEC-1];
endmodule

// File: rtl/sdm_iir6_filter_chk.sv
module sdm_iir6_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       shared_i,
  input logic       bit_valid,
  input logic       y_valid,
  input logic [2:0] want,
  input logic [2:0] grant,
  input logic [2:0] rdy
);
  // Strobe history: hist[j] holds bit_valid from j+1 cycles ago.
  logic [12:0] hist;
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[11:0], bit_valid};
  end

  // R4
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  // R3 R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid == (shared_i ? hist[12] : hist[8]));

  // R6
  single_issue_chk: assert property (@(posedge clk) disable iff (rst)
    shared_i |-> $onehot0(grant));

  // R6
  stage1_first_chk: assert property (@(posedge clk) disable iff (rst)
    want[0] |-> grant[0]);

  // R6
  stage2_order_chk: assert property (@(posedge clk) disable iff (rst)
    (want[1] && !want[0]) |-> grant[1]);

  // R9
  chain12_chk: assert property (@(posedge clk) disable iff (rst)
    rdy[0] |=> want[1]);

  // R9
  chain23_chk: assert property (@(posedge clk) disable iff (rst)
    rdy[1] |=> want[2]);
endmodule

bind sdm_iir6_filter sdm_iir6_filter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .shared_i (SHARED != 0),
  .bit_valid(bit_valid),
  .y_valid  (y_valid),
  .want     (want),
  .grant    (grant),
  .rdy      (rdy)
);

// File: tb/test_sdm_iir6_filter.sv
`timescale 1ns/1ps
module test_sdm_iir6_filter;
  localparam int W    = 32;
  localparam int FRAC = 28;
  localparam logic [15*W-1:0] COEFS = {3{
    32'sd265183082, -32'sd531072776, 32'sd293847, 32'sd589426, 32'sd295582
  }};
  localparam logic signed [31:0] ONE = 32'sd268435456;
  localparam int LAT_DED = 9;
  localparam int LAT_SHR = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bv0 = 1'b0, bv1 = 1'b0, bit_in = 1'b0;
  logic yv [2];
  logic signed [31:0] yd [2];

  always #5 clk = ~clk;

  sdm_iir6_filter #(.W(W), .FRAC(FRAC), .SHARED(1'b0), .COEFS(COEFS)) i_sdm_iir6_filter (
    .clk(clk), .rst(rst), .bit_valid(bv0), .bit_in(bit_in),
    .y_valid(yv[0]), .y_data(yd[0]));

  sdm_iir6_filter #(.W(W), .FRAC(FRAC), .SHARED(1'b1), .COEFS(COEFS)) i_sdm_iir6_filter_shr (
    .clk(clk), .rst(rst), .bit_valid(bv1), .bit_in(bit_in),
    .y_valid(yv[1]), .y_data(yd[1]));

  int checks = 0, fails = 0, tick = 0, phase = 0;
  bit done = 1'b0;
  int dq [2][$];
  logic signed [31:0] vq [2][$];
  logic signed [31:0] last [2];
  logic signed [31:0] mx1 [2][3];
  logic signed [31:0] mx2 [2][3];
  bit first_out [2];

  function automatic logic signed [31:0] cf(int i);
    return COEFS[i*32 +: 32];
  endfunction

  function automatic logic signed [31:0] fmac(logic signed [31:0] s, logic signed [31:0] k,
                                               logic signed [31:0] c);
    longint p;
    p = longint'(s) * longint'(k);
    return 32'(p >>> FRAC) + c;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // R1 R2 R9: behavioural cascade of three sections
  task automatic model(int n, logic b);
    logic signed [31:0] v, yy, x1n, x2n;
    v = b ? ONE : -ONE;
    for (int s = 0; s < 3; s++) begin
      yy  = fmac(v, cf(s*5+0), mx1[n][s]);
      x1n = fmac(v, cf(s*5+1), mx2[n][s]);
      x2n = fmac(v, cf(s*5+2), 32'sd0);
      mx1[n][s] = fmac(yy, -cf(s*5+3), x1n);
      mx2[n][s] = fmac(yy, -cf(s*5+4), x2n);
      v = yy;
    end
    dq[n].push_back(tick + (n == 0 ? LAT_DED : LAT_SHR));
    vq[n].push_back(v);
  endtask

  task automatic clear_model();
    for (int n = 0; n < 2; n++) begin
      dq[n].delete();
      vq[n].delete();
      last[n] = '0;
      first_out[n] = 1'b1;
      for (int s = 0; s < 3; s++) begin mx1[n][s] = '0; mx2[n][s] = '0; end
    end
  endtask

  task automatic compare(int n);
    bit exp_v;
    string tv, td;
    exp_v = 1'b0;
    if (dq[n].size() > 0 && dq[n][0] == tick) begin
      exp_v = 1'b1;
      last[n] = vq[n].pop_front();
      void'(dq[n].pop_front());
    end
    if (n == 0) begin
      tv = exp_v ? (phase == 2 ? "R7 valid" : "R3 valid") : "R4 valid";
      td = exp_v ? (first_out[n] ? "R1 data" : "R2 R9 data") : "R4 hold";
    end else begin
      tv = exp_v ? "R5 valid" : "R4 valid";
      td = exp_v ? (first_out[n] ? "R1 data" : "R6 data") : "R4 hold";
    end
    check(yv[n] == exp_v, tv, longint'(yv[n]), longint'(exp_v));
    check(yd[n] == last[n], td, longint'(yd[n]), longint'(last[n]));
    if (exp_v) first_out[n] = 1'b0;
  endtask

  always @(posedge clk) begin
    tick++;
    #2;
    if (!rst && !done) begin
      compare(0);
      compare(1);
    end
  end

  task automatic send(bit to0, bit to1, logic b, int gap);
    bit_in = b;
    if (to0) begin bv0 = 1'b1; model(0, b); end
    if (to1) begin bv1 = 1'b1; model(1, b); end
    @(negedge clk);
    bv0 = 1'b0;
    bv1 = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      check(yv[n] == 1'b0, "R8 reset valid", longint'(yv[n]), 0);
      check(yd[n] == 32'sd0, "R8 reset data", longint'(yd[n]), 0);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    clear_model();
    do_reset();
    // Phase 1: step response then pseudo-random bits, both modes.
    phase = 1;
    for (int i = 0; i < 60; i++) begin
      logic b;
      if (i < 30) b = 1'b1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
      end
      send(1'b1, 1'b1, b, 15 + (i % 6));
    end
    repeat (30) @(negedge clk);
    // Mid-run reset, then the dense stream on the dedicated instance.
    do_reset();
    phase = 2;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(1'b1, 1'b0, (i < 20) ? 1'b0 : lfsr[0], (i < 40) ? 5 : 5 + (i % 3));
    end
    repeat (30) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end
endmodule